// File: doc/BRIEF.md
# Linked Frame Descriptor DMA Walker

This block is a single DMA channel that follows a chain of frame descriptors held in shared memory. Software builds the chain, then starts the channel with a descriptor address and a one-cycle go strobe. For each descriptor the engine fetches the link word and the control/size word. It then fetches fragment count/address pairs one at a time and moves the fragment words between memory and a word stream. In transmit mode the words are read from memory and sent out on the stream. In receive mode words arriving on the stream are written into the fragment buffers.

When a frame is finished the engine writes the control/size word back to memory with the completion flag set, and then moves to the next descriptor. It stops and raises an end-of-chain event when the link is null, when the end-of-channel flag is set, or when it meets a descriptor that is not marked ready. A stop command ends the walk at the next fragment boundary. All memory traffic goes through one request/grant port that carries 32-bit words and uses word addresses.

Top module: `dma_chain_walker`

## Requirements
- R1: A descriptor at word address B holds the link word at B, the control/size word at B+1 (control in bits 15:0, byte size in bits 31:16), and fragment pair i at B+2+2i (byte count in bits 15:0) and B+3+2i (buffer word address). A fragment moves ceil(count/4) words, starting at its buffer address and going upward.
- R2: If bits 13:12 of the control field are not both 1, the engine returns to idle, pulses eoc_evt and writes nothing to memory.
- R3: Fragment fetching for a frame ends after a fragment whose count word has bit 31 set, or after the tenth fragment, whichever comes first.
- R4: In transmit mode (cfg_rx=0 at go) the fragment words are presented on st_out_data with st_out_valid, in fragment order and in address order.
- R5: In transmit mode a frame shorter than 16 words (64 bytes) is followed by zero words on the stream until 16 words in total have been sent.
- R6: At the end of a frame, word B+1 is rewritten with bit 14 set, bits 13:12 cleared and the other control bits kept. One cycle after that write is granted, done_evt pulses for one cycle. In transmit mode the size field is written back unchanged.
- R7: After the write-back the engine continues at the link address, unless the link is zero or control bit 11 is set. In either of those cases it goes idle and pulses eoc_evt.
- R8: In receive mode each accepted stream word is written to the current fragment address. The frame ends on the word that carries st_in_last, and the size field is written back as 4 times the number of words received.
- R9: In receive mode, if the fragments run out before st_in_last arrives, the engine stops taking stream words and writes back the frame with control bit 10 (receive error) set.
- R10: In receive mode with cfg_one_frag=1 at go, only the first fragment pair is used and later pairs are never fetched.
- R11: After cmd_stop, the engine finishes the fragment transfer in progress, makes no further memory request, writes no status, and goes idle with no event.
- R12: While mem_req is high and mem_gnt is low, the request address stays the same in the next cycle whenever the request is still raised.
- R13: After reset the engine is idle: busy, mem_req, st_out_valid, done_evt and eoc_evt are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Start strobe, taken only when idle |
| cmd_stop | input | 1 | Stop request at the next fragment boundary |
| cmd_addr | input | AW | Word address of the first descriptor |
| cfg_rx | input | 1 | 1 = receive, 0 = transmit; sampled at go |
| cfg_one_frag | input | 1 | Receive uses a single fragment; sampled at go |
| busy | output | 1 | Channel active |
| done_evt | output | 1 | One-cycle pulse per frame written back |
| eoc_evt | output | 1 | One-cycle pulse when the chain ends |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid in the granted cycle |
| st_out_valid | output | 1 | Transmit stream word valid |
| st_out_data | output | 32 | Transmit stream word |
| st_in_valid | input | 1 | Receive stream word offered |
| st_in_data | input | 32 | Receive stream word |
| st_in_last | input | 1 | Offered word ends the frame |
| st_in_ready | output | 1 | Receive word accepted this cycle |

## Verification
The assertions assume that the memory returns read data in the same cycle as the grant. They also assume that a receive source keeps st_in_valid, st_in_data and st_in_last steady until st_in_ready takes the word. The bench memory model answers from an array in the granted cycle and refuses one cycle in four, so requests wait on grant. The receive source advances only on an accepted word. Configuration inputs change only while the channel is idle, and stop is raised only during a fragment transfer.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FPTR, S_STAT, S_CNT, S_ADR, S_XFER, S_PAD, S_WB
  } walk_st_e;

  localparam int unsigned SIZE_W     = 16;
  localparam int unsigned LAST_BIT   = 31;
  localparam int unsigned DONE_BIT   = 14;
  localparam int unsigned RDY_HI     = 13;
  localparam int unsigned RDY_LO     = 12;
  localparam int unsigned EOC_BIT    = 11;
  localparam int unsigned RXERR_BIT  = 10;

  // byte count rounded up to whole 32-bit words
  function automatic logic [31:0] words_of(input logic [31:0] nbytes);
    return (nbytes + 32'd3) >> 2;
  endfunction

  // control field as written back at frame completion
  function automatic logic [15:0] done_ctl(input logic [15:0] ctl, input logic rx_err);
    logic [15:0] c;
    c = ctl;
    c[RDY_HI]   = 1'b0;
    c[RDY_LO]   = 1'b0;
    c[DONE_BIT] = 1'b1;
    if (rx_err) c[RXERR_BIT] = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/dcw_addr_gen.sv
module dcw_addr_gen
  import dcw_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned FIW = 4
) (
  input  walk_st_e       st,
  input  logic [AW-1:0]  base,
  input  logic [FIW-1:0] fidx,
  input  logic [AW-1:0]  xaddr,
  output logic [AW-1:0]  addr
);
  logic [AW-1:0] pair_off;

  assign pair_off = AW'({fidx, 1'b0});

  always_comb begin
    case (st)
      S_FPTR:  addr = base;
      S_STAT:  addr = base + AW'(1);
      S_WB:    addr = base + AW'(1);
      S_CNT:   addr = base + AW'(2) + pair_off;
      S_ADR:   addr = base + AW'(3) + pair_off;
      S_XFER:  addr = xaddr;
      default: addr = base;
    endcase
  end
endmodule

// File: rtl/dcw_wb_fmt.sv
module dcw_wb_fmt
  import dcw_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic [15:0]     ctl,
  input  logic [15:0]     size,
  input  logic [CW-1:0]   total_w,
  input  logic            rx,
  input  logic            rx_err,
  output logic [31:0]     word
);
  logic [15:0] rx_bytes;

  assign rx_bytes = 16'(total_w << 2);
  assign word     = {(rx ? rx_bytes : size), done_ctl(ctl, rx_err)};
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
  import dcw_pkg::*;
#(
  parameter int unsigned AW              = 16,
  parameter int unsigned MAX_FRAGS       = 10,
  parameter int unsigned MIN_FRAME_BYTES = 64,
  parameter int unsigned CW              = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic          cmd_stop,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cfg_rx,
  input  logic          cfg_one_frag,
  output logic          busy,
  output logic          done_evt,
  output logic          eoc_evt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          st_out_valid,
  output logic [31:0]   st_out_data,
  input  logic          st_in_valid,
  input  logic [31:0]   st_in_data,
  input  logic          st_in_last,
  output logic          st_in_ready
);
  localparam int unsigned FIW  = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1;
  localparam int unsigned MINW = MIN_FRAME_BYTES / 4;

  walk_st_e       state;
  logic [AW-1:0]  base, fptr, xaddr;
  logic [15:0]    ctl, size;
  logic [FIW-1:0] fidx;
  logic           cnt_last, rx_q, one_q, rx_err, stop_pend;
  logic [CW-1:0]  words_left, total_w;

  // named internal events
  logic           acc, xfer_beat, frag_fin, rx_last_beat, final_frag;
  logic [CW-1:0]  tot_now;
  walk_st_e       af_state;
  logic           af_err, af_inc;
  logic [31:0]    wb_word;

  dcw_addr_gen #(.AW(AW), .FIW(FIW)) u_addr (
    .st(state), .base(base), .fidx(fidx), .xaddr(xaddr), .addr(mem_addr)
  );

  dcw_wb_fmt #(.CW(CW)) u_fmt (
    .ctl(ctl), .size(size), .total_w(total_w), .rx(rx_q), .rx_err(rx_err), .word(wb_word)
  );

  always_comb begin
    case (state)
      S_FPTR, S_STAT, S_CNT, S_ADR, S_WB: mem_req = !stop_pend;
      S_XFER:  mem_req = rx_q ? st_in_valid : 1'b1;
      default: mem_req = 1'b0;
    endcase
  end

  assign mem_we       = (state == S_WB) || (state == S_XFER && rx_q);
  assign mem_wdata    = (state == S_WB) ? wb_word : st_in_data;
  assign acc          = mem_req && mem_gnt;
  assign xfer_beat    = (state == S_XFER) && acc;
  assign rx_last_beat = xfer_beat && rx_q && st_in_last;
  assign frag_fin     = xfer_beat && ((words_left == CW'(1)) || rx_last_beat);
  assign final_frag   = cnt_last || (fidx == FIW'(MAX_FRAGS - 1)) || (rx_q && one_q);
  assign tot_now      = xfer_beat ? total_w + CW'(1) : total_w;
  assign busy         = (state != S_IDLE);
  assign st_in_ready  = xfer_beat && rx_q;
  assign st_out_valid = (xfer_beat && !rx_q) || (state == S_PAD && !stop_pend);
  assign st_out_data  = (state == S_XFER) ? mem_rdata : 32'd0;

  // where to go once a fragment has been handled
  always_comb begin
    af_state = S_CNT;
    af_err   = 1'b0;
    af_inc   = 1'b0;
    if (stop_pend || cmd_stop) begin
      af_state = S_IDLE;
    end else if (rx_last_beat) begin
      af_state = S_WB;
    end else if (final_frag) begin
      if (rx_q) begin
        af_state = S_WB;
        af_err   = 1'b1;
      end else begin
        af_state = (tot_now < CW'(MINW)) ? S_PAD : S_WB;
      end
    end else begin
      af_inc = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      base       <= '0;
      fptr       <= '0;
      xaddr      <= '0;
      ctl        <= '0;
      size       <= '0;
      fidx       <= '0;
      cnt_last   <= 1'b0;
      rx_q       <= 1'b0;
      one_q      <= 1'b0;
      rx_err     <= 1'b0;
      stop_pend  <= 1'b0;
      words_left <= '0;
      total_w    <= '0;
      done_evt   <= 1'b0;
      eoc_evt    <= 1'b0;
    end else begin
      done_evt <= 1'b0;
      eoc_evt  <= 1'b0;
      if (cmd_stop && state != S_IDLE) stop_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          stop_pend <= 1'b0;
          if (cmd_go) begin
            base  <= cmd_addr;
            rx_q  <= cfg_rx;
            one_q <= cfg_one_frag;
            state <= S_FPTR;
          end
        end
        S_FPTR: begin
          if (stop_pend) state <= S_IDLE;
          else if (acc) begin
            fptr  <= mem_rdata[AW-1:0];
            state <= S_STAT;
          end
        end
        S_STAT: begin
          if (stop_pend) state <= S_IDLE;
          else if (acc) begin
            ctl  <= mem_rdata[15:0];
            size <= mem_rdata[31:16];
            if (mem_rdata[RDY_HI:RDY_LO] != 2'b11) begin
              state   <= S_IDLE;
              eoc_evt <= 1'b1;
            end else begin
              fidx    <= '0;
              total_w <= '0;
              rx_err  <= 1'b0;
              state   <= S_CNT;
            end
          end
        end
        S_CNT: begin
          if (stop_pend) state <= S_IDLE;
          else if (acc) begin
            cnt_last   <= mem_rdata[LAST_BIT];
            words_left <= CW'(words_of(32'(mem_rdata[CW-1:0])));
            state      <= S_ADR;
          end
        end
        S_ADR: begin
          if (stop_pend) state <= S_IDLE;
          else if (acc) begin
            xaddr <= mem_rdata[AW-1:0];
            if (words_left == '0) begin
              state <= af_state;
              if (af_err) rx_err <= 1'b1;
              if (af_inc) fidx <= fidx + FIW'(1);
            end else begin
              state <= S_XFER;
            end
          end
        end
        S_XFER: begin
          if (xfer_beat) begin
            xaddr      <= xaddr + AW'(1);
            words_left <= words_left - CW'(1);
            total_w    <= tot_now;
            if (frag_fin) begin
              state <= af_state;
              if (af_err) rx_err <= 1'b1;
              if (af_inc) fidx <= fidx + FIW'(1);
            end
          end
        end
        S_PAD: begin
          if (stop_pend) state <= S_IDLE;
          else begin
            total_w <= total_w + CW'(1);
            if (total_w + CW'(1) >= CW'(MINW)) state <= S_WB;
          end
        end
        S_WB: begin
          if (stop_pend) state <= S_IDLE;
          else if (acc) begin
            done_evt <= 1'b1;
            if (ctl[EOC_BIT] || fptr == '0) begin
              state   <= S_IDLE;
              eoc_evt <= 1'b1;
            end else begin
              base  <= fptr;
              state <= S_FPTR;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (!mem_req || $stable(mem_addr)));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !st_out_valid));

  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> $past(mem_req && mem_we && mem_gnt));

  // R5
  pad_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !rx_q) |-> (total_w >= CW'(MINW)));

  // R3
  fidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fidx < FIW'(MAX_FRAGS)));

  // R7
  eoc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_evt |-> !busy);

endmodule

// File: tb/dma_chain_walker_bench.sv
module dma_chain_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  // {frag count, bytes per frag, index of last-flagged frag (FF = none), expected stream words}
  localparam logic [31:0] TX_VEC [6] = '{
    32'h01_08_00_10, 32'h02_28_01_14, 32'h03_07_02_10,
    32'h0A_08_FF_14, 32'h02_24_00_10, 32'h01_40_00_10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_go = 1'b0, cmd_stop = 1'b0, cfg_rx = 1'b0, cfg_one_frag = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic busy, done_evt, eoc_evt, mem_req, mem_we, mem_gnt;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, st_out_data, st_in_data;
  logic st_out_valid, st_in_valid, st_in_last, st_in_ready;

  logic [31:0] mem [256];
  logic [31:0] cap [64];
  logic [31:0] rx_src [8];
  int cap_n, done_cnt, eoc_cnt, hold_err, rx_idx, rx_len;
  logic rx_last_en = 1'b0, clr = 1'b0;
  logic [1:0] gcnt;
  logic p_wait;
  logic [AW-1:0] p_addr;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_walker u_dma_chain_walker (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_stop(cmd_stop), .cmd_addr(cmd_addr),
    .cfg_rx(cfg_rx), .cfg_one_frag(cfg_one_frag), .busy(busy), .done_evt(done_evt),
    .eoc_evt(eoc_evt), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .st_out_valid(st_out_valid), .st_out_data(st_out_data), .st_in_valid(st_in_valid),
    .st_in_data(st_in_data), .st_in_last(st_in_last), .st_in_ready(st_in_ready)
  );

  assign mem_gnt     = (gcnt != 2'd2);
  assign mem_rdata   = mem[mem_addr[7:0]];
  assign st_in_valid = (rx_idx < rx_len);
  assign st_in_data  = rx_src[rx_idx[2:0]];
  assign st_in_last  = rx_last_en && (rx_idx == rx_len - 1);

  always @(posedge clk) begin
    gcnt <= rst_n ? gcnt + 2'd1 : 2'd0;
    if (mem_req && mem_we && mem_gnt) mem[mem_addr[7:0]] <= mem_wdata;
    p_wait <= rst_n && mem_req && !mem_gnt;
    p_addr <= mem_addr;
    if (!rst_n) hold_err <= 0;
    else if (p_wait && mem_req && mem_addr != p_addr) hold_err <= hold_err + 1;
    if (clr) begin
      cap_n <= 0; done_cnt <= 0; eoc_cnt <= 0; rx_idx <= 0;
    end else begin
      if (st_out_valid && cap_n < 64) begin
        cap[cap_n] <= st_out_data;
        cap_n <= cap_n + 1;
      end
      if (done_evt) done_cnt <= done_cnt + 1;
      if (eoc_evt) eoc_cnt <= eoc_cnt + 1;
      if (st_in_ready) rx_idx <= rx_idx + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | i;
  endtask

  task automatic run(input logic [AW-1:0] a, input logic rx, input logic one, input int stop_at);
    int n;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    cmd_addr = a; cfg_rx = rx; cfg_one_frag = one; cmd_go = 1'b1;
    @(negedge clk); cmd_go = 1'b0;
    n = 0;
    while (busy && n < 3000) begin
      if (n == stop_at) cmd_stop = 1'b1;
      @(negedge clk);
      cmd_stop = 1'b0;
      n++;
    end
    chk(n < 3000, "watchdog run", n, 3000);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    int nfr, nby, lat, ew, nused, idx, wpf;
    logic data_ok, pad_ok;
    clear_mem();
    rx_len = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!busy && !mem_req && !st_out_valid && !done_evt && !eoc_evt, "R13 reset idle",
        {busy, mem_req, st_out_valid, done_evt, eoc_evt}, 0);
    rst_n = 1'b1;

    // stimulus table: transmit frames
    for (int v = 0; v < 6; v++) begin
      nfr = TX_VEC[v][31:24]; nby = TX_VEC[v][23:16]; lat = TX_VEC[v][15:8]; ew = TX_VEC[v][7:0];
      clear_mem();
      mem[8'h10] = 32'h0; mem[8'h11] = 32'h0055_3100;
      for (int k = 0; k < nfr; k++) begin
        mem[8'h12 + 2*k] = nby | ((k == lat) ? 32'h8000_0000 : 32'h0);
        mem[8'h13 + 2*k] = 32'h40 + 16*k;
      end
      run(16'h10, 1'b0, 1'b0, -1);
      nused = (lat == 8'hFF) ? nfr : lat + 1;
      wpf = (nby + 3) / 4;
      idx = 0; data_ok = 1'b1;
      for (int k = 0; k < nused; k++)
        for (int w = 0; w < wpf; w++) begin
          if (cap[idx] != (32'hA000_0000 | (32'h40 + 16*k + w))) data_ok = 1'b0;
          idx++;
        end
      pad_ok = 1'b1;
      for (int p = idx; p < ew; p++) if (cap[p] != 0) pad_ok = 1'b0;
      chk(cap_n == ew, "R3 R5 stream length", cap_n, ew);
      chk(data_ok, "R1 R4 fragment data order", {31'b0, data_ok}, 1);
      chk(pad_ok, "R5 pad words zero", {31'b0, pad_ok}, 1);
      chk(mem[8'h11] == 32'h0055_4100, "R6 tx writeback", mem[8'h11], 32'h0055_4100);
      chk(done_cnt == 1 && eoc_cnt == 1, "R7 null link ends chain", {done_cnt[15:0], eoc_cnt[15:0]}, 32'h0001_0001);
    end

    // R7 chain following with end-of-channel flag
    clear_mem();
    mem[8'h10] = 32'h30; mem[8'h11] = 32'h0001_3000; mem[8'h12] = 32'h8000_0004; mem[8'h13] = 32'h40;
    mem[8'h30] = 32'h50; mem[8'h31] = 32'h0002_3800; mem[8'h32] = 32'h8000_0004; mem[8'h33] = 32'h41;
    mem[8'h51] = 32'h0003_3000;
    run(16'h10, 1'b0, 1'b0, -1);
    chk(mem[8'h11] == 32'h0001_4000, "R7 first frame written", mem[8'h11], 32'h0001_4000);
    chk(mem[8'h31] == 32'h0002_4800, "R6 eoc bit kept", mem[8'h31], 32'h0002_4800);
    chk(mem[8'h51] == 32'h0003_3000, "R7 stops at eoc flag", mem[8'h51], 32'h0003_3000);
    chk(done_cnt == 2 && eoc_cnt == 1 && cap_n == 32, "R7 two frames one eoc",
        {done_cnt[7:0], eoc_cnt[7:0], cap_n[15:0]}, 32'h0201_0020);

    // R2 descriptor not ready
    clear_mem();
    mem[8'h10] = 32'h0; mem[8'h11] = 32'h0000_1000;
    run(16'h10, 1'b0, 1'b0, -1);
    chk(mem[8'h11] == 32'h0000_1000 && done_cnt == 0, "R2 no writeback", mem[8'h11], 32'h0000_1000);
    chk(eoc_cnt == 1 && cap_n == 0, "R2 eoc raised", {eoc_cnt[15:0], cap_n[15:0]}, 32'h0001_0000);

    // R8 receive over two fragments, last on third word
    clear_mem();
    for (int i = 0; i < 8; i++) rx_src[i] = 32'h1111_0000 + i;
    rx_len = 3; rx_last_en = 1'b1;
    mem[8'h10] = 32'h0; mem[8'h11] = 32'h0000_3000;
    mem[8'h12] = 32'h8; mem[8'h13] = 32'h40; mem[8'h14] = 32'h8000_0008; mem[8'h15] = 32'h50;
    run(16'h10, 1'b1, 1'b0, -1);
    chk(mem[8'h40] == 32'h1111_0000 && mem[8'h41] == 32'h1111_0001, "R8 first frag filled", mem[8'h41], 32'h1111_0001);
    chk(mem[8'h50] == 32'h1111_0002 && mem[8'h51] == 32'hA000_0051, "R8 stops at last", mem[8'h51], 32'hA000_0051);
    chk(mem[8'h11] == 32'h000C_4000, "R8 rx size writeback", mem[8'h11], 32'h000C_4000);
    chk(cap_n == 0, "R8 no tx stream", cap_n, 0);

    // R9 R10 one-fragment receive overflow
    clear_mem();
    rx_len = 4; rx_last_en = 1'b0;
    mem[8'h10] = 32'h0; mem[8'h11] = 32'h0000_3000;
    mem[8'h12] = 32'h8; mem[8'h13] = 32'h40; mem[8'h14] = 32'h8000_0008; mem[8'h15] = 32'h50;
    run(16'h10, 1'b1, 1'b1, -1);
    chk(mem[8'h50] == 32'hA000_0050, "R10 second pair unused", mem[8'h50], 32'hA000_0050);
    chk(mem[8'h11] == 32'h0008_4400, "R9 overflow error bit", mem[8'h11], 32'h0008_4400);
    chk(rx_idx == 2, "R9 extra words refused", rx_idx, 2);
    rx_len = 0;

    // R11 stop during a long fragment
    clear_mem();
    mem[8'h10] = 32'h0; mem[8'h11] = 32'h0000_3000;
    mem[8'h12] = 32'hA0; mem[8'h13] = 32'h40; mem[8'h14] = 32'h8000_0008; mem[8'h15] = 32'h80;
    run(16'h10, 1'b0, 1'b0, 12);
    chk(cap_n == 40, "R11 fragment completed", cap_n, 40);
    chk(mem[8'h11] == 32'h0000_3000, "R11 no writeback", mem[8'h11], 32'h0000_3000);
    chk(done_cnt == 0 && eoc_cnt == 0 && !busy, "R11 idle no events", {done_cnt[15:0], eoc_cnt[15:0]}, 0);

    chk(hold_err == 0, "R12 address held while waiting", hold_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule